// File: doc/BRIEF.md
# Dual-Lane Fractional Multiply-Accumulate Unit

This block is a two-lane SIMD multiply-accumulate datapath for signal-processing loops such as FIR filters. Each 32-bit operand word carries two independent signed 16-bit elements in 1.15 fractional format. One operand is a data vector. The other is a coefficient vector, which usually holds the same coefficient copied into both halves. Each lane multiplies its two elements as fractions. The raw product is doubled to remove the redundant sign bit. The lane then either loads that product into its own 32-bit accumulator or adds it to the value already there. When the result goes out of range, the lane either clamps it or wraps it, as the operation selects.

The two lane accumulators are presented together as one 64-bit pair. The upper halfword of each lane is also presented as a packed pair of 16-bit results. The unit raises a per-lane overflow flag for each operation. It also keeps a sticky overflow flag that a dedicated input clears.

An operation is accepted on a clock edge where `in_valid` is high. Its result and `out_valid` appear one cycle later. Between operations the accumulators and the per-lane flags hold their values.

Top module: `q15_dual_mac`

## Requirements
- R1: The even lane takes operand bits 31:16 and writes `acc_pair[63:32]`, `hi_pair[31:16]` and `lane_ovf[1]`. The odd lane takes bits 15:0 and writes `acc_pair[31:0]`, `hi_pair[15:0]` and `lane_ovf[0]`. Neither lane's result depends on the other lane's operands.
- R2: The lane product is the signed 16x16 product shifted left by one with a zero LSB. For example, loading 0x6000 x 0x6000 yields the accumulator value 0x48000000.
- R3: With `op_acc`=0 (load form), the lane accumulator is replaced by the doubled product.
- R4: With `op_acc`=1 (accumulate form), the doubled product is added to the lane accumulator, and the sum becomes the new accumulator value.
- R5: With `op_sat`=1, a result above 0x7FFFFFFF clamps to 0x7FFFFFFF and a result below 0x80000000 (as signed) clamps to 0x80000000. This includes loading 0x8000 x 0x8000, which gives 0x7FFFFFFF.
- R6: With `op_sat`=0, an out-of-range result keeps only its low 32 bits. For example, loading 0x8000 x 0x8000 gives 0x80000000.
- R7: On each accepted operation, `lane_ovf` is set for every lane whose exact result lies outside the signed 32-bit range, in both modes, and is cleared for every other lane.
- R8: `ovf_sticky` is set by any lane overflow of an accepted operation and is cleared by `ovf_clr`. If both happen in the same cycle, the set wins.
- R9: `out_valid` rises in the cycle after `in_valid` is sampled high. When `in_valid` is low, `acc_pair` and `lane_ovf` keep their values.
- R10: While `rst_n` is low, both accumulators, `lane_ovf`, `ovf_sticky` and `out_valid` are zero.
- R11: `hi_pair` holds the upper 16 bits of each lane accumulator, in the lane order of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| in_valid | input | 1 | Accept an operation this cycle |
| op_acc | input | 1 | 0 = load the product, 1 = add the product to the accumulator |
| op_sat | input | 1 | 1 = clamp on overflow, 0 = wrap |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| data_word | input | 32 | Data vector, two 1.15 elements |
| coef_word | input | 32 | Coefficient vector, two 1.15 elements |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| acc_pair | output | 64 | Even lane accumulator in bits 63:32, odd lane accumulator in bits 31:0 |
| hi_pair | output | 32 | Upper halfword of each lane accumulator |
| lane_ovf | output | 2 | Per-lane overflow flag of the last operation |
| ovf_sticky | output | 1 | Sticky overflow flag |

## Verification
Two functions of this block can fall in the same cycle: clearing the sticky flag, and a lane overflow that sets it. The bench provokes the collision by asserting `ovf_clr` together with an operation that overflows one lane, and expects `ovf_sticky` to stay high. It also asserts `ovf_clr` with an operation that does not overflow, and expects the flag to drop. A behavioural reference model with exact integer arithmetic predicts every output on every clock. The bench compares the outputs both across these collisions and across a long pseudo-random mix of load, accumulate, clamp and wrap operations.

// File: rtl/q15_mac_pkg.sv
package q15_mac_pkg;
  typedef enum logic {
    FORM_LOAD = 1'b0,
    FORM_ACC  = 1'b1
  } mac_form_e;

  typedef enum logic {
    RANGE_WRAP  = 1'b0,
    RANGE_CLAMP = 1'b1
  } range_mode_e;
endpackage

// File: rtl/q15_frac_mul.sv
module q15_frac_mul #(
  parameter int EW = 16
) (
  input  logic [EW-1:0]  elem_a,
  input  logic [EW-1:0]  elem_b,
  output logic [2*EW:0]  prod_x2
);
  localparam int PW = 2 * EW;

  logic signed [EW-1:0] sa;
  logic signed [EW-1:0] sb;
  logic signed [PW-1:0] raw;

  always_comb begin
    sa      = elem_a;
    sb      = elem_b;
    raw     = sa * sb;
    // drop the duplicated sign bit: double the product, zero into the LSB
    prod_x2 = {raw, 1'b0};
  end
endmodule

// File: rtl/q15_lane_sum.sv
module q15_lane_sum
  import q15_mac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW:0]    prod_x2,
  input  logic [AW-1:0]  acc_q,
  input  mac_form_e      form,
  input  range_mode_e    mode,
  output logic [AW-1:0]  res,
  output logic           ovf
);
  localparam int SW = AW + 2;
  localparam logic [AW-1:0] POS_LIM = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] NEG_LIM = {1'b1, {(AW-1){1'b0}}};

  logic [SW-1:0] ext_p;
  logic [SW-1:0] ext_a;
  logic [SW-1:0] sum;
  logic [2:0]    guard;

  always_comb begin
    ext_p = {prod_x2[AW], prod_x2};
    ext_a = {{2{acc_q[AW-1]}}, acc_q};
    sum   = (form == FORM_ACC) ? (ext_a + ext_p) : ext_p;
    guard = sum[SW-1:AW-1];
    ovf   = !((&guard) || (~|guard));
    if (ovf && (mode == RANGE_CLAMP)) begin
      res = sum[SW-1] ? NEG_LIM : POS_LIM;
    end else begin
      res = sum[AW-1:0];
    end
  end
endmodule

// File: rtl/q15_dual_mac.sv
module q15_dual_mac
  import q15_mac_pkg::*;
#(
  parameter int EW    = 16,
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  op_acc,
  input  logic                  op_sat,
  input  logic                  ovf_clr,
  input  logic [LANES*EW-1:0]   data_word,
  input  logic [LANES*EW-1:0]   coef_word,
  output logic                  out_valid,
  output logic [LANES*2*EW-1:0] acc_pair,
  output logic [LANES*EW-1:0]   hi_pair,
  output logic [LANES-1:0]      lane_ovf,
  output logic                  ovf_sticky
);
  localparam int AW = 2 * EW;

  mac_form_e   form;
  range_mode_e mode;

  logic [AW-1:0]    acc_q   [LANES];
  logic [AW-1:0]    acc_d   [LANES];
  logic [LANES-1:0] lane_ov;
  logic [LANES-1:0] ovf_q;
  logic [LANES-1:0] ovf_d;
  logic             sticky_q;
  logic             sticky_d;
  logic             vld_q;
  logic             vld_d;
  logic             acc_en;

  assign form   = mac_form_e'(op_acc);
  assign mode   = range_mode_e'(op_sat);
  assign acc_en = in_valid;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AW:0] px2;

    q15_frac_mul #(.EW(EW)) u_mul (
      .elem_a  (data_word[g*EW +: EW]),
      .elem_b  (coef_word[g*EW +: EW]),
      .prod_x2 (px2)
    );

    q15_lane_sum #(.AW(AW)) u_sum (
      .prod_x2 (px2),
      .acc_q   (acc_q[g]),
      .form    (form),
      .mode    (mode),
      .res     (acc_d[g]),
      .ovf     (lane_ov[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[g] <= '0;
      end else if (acc_en) begin
        acc_q[g] <= acc_d[g];
      end
    end

    assign acc_pair[g*AW +: AW] = acc_q[g];
    assign hi_pair[g*EW +: EW]  = acc_q[g][AW-1 -: EW];
  end

  // next-state for flags and valid
  always_comb begin
    vld_d    = in_valid;
    ovf_d    = in_valid ? lane_ov : ovf_q;
    sticky_d = (sticky_q && !ovf_clr) || (in_valid && (|lane_ov));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      ovf_q    <= '0;
      sticky_q <= 1'b0;
    end else begin
      vld_q    <= vld_d;
      ovf_q    <= ovf_d;
      sticky_q <= sticky_d;
    end
  end

  assign out_valid  = vld_q;
  assign lane_ovf   = ovf_q;
  assign ovf_sticky = sticky_q;
endmodule

// File: rtl/q15_dual_mac_chk.sv
module q15_dual_mac_chk #(
  parameter int EW    = 16,
  parameter int LANES = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  op_sat,
  input logic                  ovf_clr,
  input logic                  out_valid,
  input logic [LANES*2*EW-1:0] acc_pair,
  input logic [LANES-1:0]      lane_ovf,
  input logic                  ovf_sticky
);
  localparam int AW = 2 * EW;
  localparam logic [AW-1:0] POS_LIM = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] NEG_LIM = {1'b1, {(AW-1){1'b0}}};

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_pair) && $stable(lane_ovf));

  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (|lane_ovf)) |-> ovf_sticky);

  assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !in_valid) |=> !ovf_sticky);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    assert_clamp_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sat) |=>
        (!lane_ovf[g] || acc_pair[g*AW +: AW] == POS_LIM || acc_pair[g*AW +: AW] == NEG_LIM));
  end
endmodule

bind q15_dual_mac q15_dual_mac_chk #(.EW(EW), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op_sat     (op_sat),
  .ovf_clr    (ovf_clr),
  .out_valid  (out_valid),
  .acc_pair   (acc_pair),
  .lane_ovf   (lane_ovf),
  .ovf_sticky (ovf_sticky)
);

// File: tb/sim_q15_dual_mac.sv
`timescale 1ns/1ps
module sim_q15_dual_mac;
  localparam longint MAXV = 64'sd2147483647;
  localparam longint MINV = -64'sd2147483648;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, op_acc = 1'b0, op_sat = 1'b0, ovf_clr = 1'b0;
  logic [31:0] data_word = '0, coef_word = '0;
  logic        out_valid;
  logic [63:0] acc_pair;
  logic [31:0] hi_pair;
  logic [1:0]  lane_ovf;
  logic        ovf_sticky;

  int total = 0;
  int bad   = 0;

  // reference model state: lane 1 = even (bits 31:16), lane 0 = odd
  longint m_acc [2];
  bit [1:0] m_ovf;
  bit       m_sticky;
  bit       m_vld;
  string    cur_tag = "R10";

  always #2 clk = ~clk;

  q15_dual_mac u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_acc(op_acc),
    .op_sat(op_sat), .ovf_clr(ovf_clr), .data_word(data_word),
    .coef_word(coef_word), .out_valid(out_valid), .acc_pair(acc_pair),
    .hi_pair(hi_pair), .lane_ovf(lane_ovf), .ovf_sticky(ovf_sticky)
  );

  task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic longint lane_step(input logic [15:0] a, input logic [15:0] b,
                                       input longint acc, input bit accm, input bit sat,
                                       output bit ov);
    longint p, s;
    p  = longint'($signed(a)) * longint'($signed(b)) * 2;
    s  = accm ? acc + p : p;
    ov = (s > MAXV) || (s < MINV);
    if (ov) s = sat ? ((s > 0) ? MAXV : MINV) : longint'($signed(s[31:0]));
    return s;
  endfunction

  task automatic compare_all();
    logic [63:0] ea;
    logic [31:0] eh;
    ea = {m_acc[1][31:0], m_acc[0][31:0]};
    eh = {ea[63:48], ea[31:16]};
    check(cur_tag, "acc_pair", acc_pair, ea);
    check("R11", "hi_pair", {32'h0, hi_pair}, {32'h0, eh});
    check("R7", "lane_ovf", {62'h0, lane_ovf}, {62'h0, m_ovf});
    check("R8", "ovf_sticky", {63'h0, ovf_sticky}, {63'h0, m_sticky});
    check("R9", "out_valid", {63'h0, out_valid}, {63'h0, m_vld});
  endtask

  // compare at the negedge, then drive the next operation and advance the model
  task automatic step(input bit v, input bit accm, input bit sat, input bit clr,
                      input logic [31:0] d, input logic [31:0] c);
    bit [1:0] ov;
    @(negedge clk);
    compare_all();
    in_valid = v; op_acc = accm; op_sat = sat; ovf_clr = clr;
    data_word = d; coef_word = c;
    ov = '0;
    if (v) begin
      m_acc[1] = lane_step(d[31:16], c[31:16], m_acc[1], accm, sat, ov[1]);
      m_acc[0] = lane_step(d[15:0],  c[15:0],  m_acc[0], accm, sat, ov[0]);
      m_ovf = ov;
    end
    m_sticky = (m_sticky && !clr) || (v && (|ov));
    m_vld = v;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 32'h0, 32'h0);
  endtask

  initial begin
    #(4ns * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    m_acc[0] = 0; m_acc[1] = 0; m_ovf = '0; m_sticky = 0; m_vld = 0;

    // R10: reset state
    repeat (3) @(negedge clk);
    compare_all();
    check("R10", "acc_pair reset", acc_pair, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R3: load 0.75 * 0.75 into both lanes
    cur_tag = "R2";
    step(1, 0, 1, 0, 32'h6000_6000, 32'h6000_6000);
    idle();
    check("R2", "load 0x6000^2", acc_pair, 64'h48000000_48000000);
    check("R11", "upper halves", {32'h0, hi_pair}, 64'h48004800);

    // R1: lanes independent, distinct data
    cur_tag = "R1";
    step(1, 0, 1, 0, 32'h4000_C000, 32'h2000_2000);
    idle();
    check("R1", "lane split", acc_pair, 64'h10000000_F0000000);

    // R4: accumulate a few products
    cur_tag = "R4";
    step(1, 1, 1, 0, 32'h1000_0100, 32'h7FFF_8000);
    step(1, 1, 1, 0, 32'hF000_0200, 32'h0400_0400);
    step(1, 1, 0, 0, 32'h1234_8765, 32'h2000_2000);
    // R9: idle cycles hold everything
    cur_tag = "R9";
    idle(); idle(); idle();

    // R5 / R7: -1 * -1 with clamp on even lane, non-overflowing odd lane
    cur_tag = "R5";
    step(1, 0, 1, 0, 32'h8000_8000, 32'h8000_7FFF);
    idle();
    check("R5", "clamp -1*-1", acc_pair[63:32], 64'h7FFFFFFF);
    check("R7", "ovf even only", {62'h0, lane_ovf}, 64'h2);

    // R6: same product wrapped
    cur_tag = "R6";
    step(1, 0, 0, 0, 32'h8000_8000, 32'h8000_8000);
    idle();
    check("R6", "wrap -1*-1", acc_pair, 64'h80000000_80000000);

    // R5: negative clamp through accumulation
    cur_tag = "R5";
    step(1, 0, 1, 0, 32'h8000_8000, 32'h7FFF_7FFF);
    step(1, 1, 1, 0, 32'h8000_8000, 32'h7FFF_4000);
    idle();
    check("R5", "negative clamp", acc_pair[63:32], 64'h80000000);

    // R8: clear without overflow drops sticky, clear colliding with overflow keeps it
    cur_tag = "R8";
    step(1, 0, 1, 1, 32'h0100_0100, 32'h0100_0100);
    idle();
    check("R8", "clear wins without ovf", {63'h0, ovf_sticky}, 64'h0);
    step(1, 0, 1, 0, 32'h8000_8000, 32'h8000_8000);
    step(1, 0, 1, 1, 32'h8000_0000, 32'h8000_0000);
    idle();
    check("R8", "set wins over clear", {63'h0, ovf_sticky}, 64'h1);
    step(0, 0, 0, 1, 32'h0, 32'h0);
    idle();
    check("R8", "idle clear", {63'h0, ovf_sticky}, 64'h0);

    // R4: pseudo-random mix checked against the model every cycle
    cur_tag = "R4";
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d, c;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      d  = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      c  = lf;
      step(lf[3] | lf[9], lf[5] | lf[7], lf[11], lf[13] & lf[2], d, c);
    end
    idle();
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule